// File: doc/BRIEF.md
# Multithreaded Stream Issue Scheduler

This block sits at the front of a barrel-style multithreaded core. It holds a pool of independent hardware stream contexts and, each clock, picks at most one of them to issue its next instruction word. An instruction word has three operation slots: memory, arithmetic and control. Only the memory slot matters to the scheduler. It keeps a status word with a program counter for each stream. The chosen stream's index is all the register files need to find that stream's context.

A stream is eligible when four things hold: it has been started, it has no instruction still in the pipeline, the fetch side reports its next word ready, and it is not too far ahead of its oldest unfinished memory operation. Memory operations get a per-stream tag from an 8-entry window, in issue order. Completions come back tagged with stream and window tag, in any order. Only the oldest outstanding operation limits how far a stream may run ahead. When no stream is eligible, the scheduler issues nothing in that cycle. Among eligible streams, a rotating pointer gives fair service.

Top module: `stream_issue_sched`

## Requirements
- R1: After reset every stream is inactive, and `issue_valid` stays 0 until some stream has been started.
- R2: A `start_valid` pulse for an inactive stream activates it and loads `start_pc` into its PC, and the stream can issue from the next cycle. A start for a stream that is already active has no effect on its PC.
- R3: `issue_pc` is the issuing stream's current PC, and each issue of a stream increments its PC by one.
- R4: A stream that issues in cycle c cannot issue again before cycle c+PIPE_LAT+1, when its instruction has left the pipeline.
- R5: Once a stream has issued a memory operation, it may issue at most LOOKAHEAD (7) further instructions until that operation completes.
- R6: A stream's memory operations take tags 0,1,2,…,7,0,… in the order they issue, counting per stream. `issue_tag` is 0 when `issue_mem` is 0.
- R7: A completion takes effect from the next cycle. A completion whose tag is not outstanding for that stream is ignored.
- R8: The issuing stream is the first eligible stream found by searching upward with wrap-around, starting at the rotating pointer. After each issue the pointer moves to the issued stream's index plus one, modulo the stream count.
- R9: In a cycle with no eligible stream, `issue_valid` and `issue_mem` are 0.
- R10: A stream whose `inst_rdy` bit is 0 is not eligible. `issue_mem` copies the issuing stream's `mem_slot` bit.
- R11: Only the oldest outstanding memory operation limits issue. Completing a younger operation does not release a blocked stream, and completing the oldest one does, even while younger ones stay outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start request for one stream |
| start_sid | input | SID_W | Stream to start |
| start_pc | input | PC_W | Initial PC of the started stream |
| inst_rdy | input | N_STREAMS | Per stream: next instruction word available |
| mem_slot | input | N_STREAMS | Per stream: next word has a memory operation |
| cmp_valid | input | 1 | Memory completion valid |
| cmp_sid | input | SID_W | Stream of the completed operation |
| cmp_tag | input | TAG_W | Window tag of the completed operation |
| issue_valid | output | 1 | A stream issues this cycle |
| issue_sid | output | SID_W | Issuing stream index |
| issue_pc | output | PC_W | PC of the issued word |
| issue_mem | output | 1 | Issued word carries a memory operation |
| issue_tag | output | TAG_W | Window tag given to that memory operation |

## Verification
The checker tests several properties on every cycle. It confirms that a stall issues no memory operation and that no stream issues in two cycles back to back. It confirms that only a stream reporting a ready word issues, that nothing issues before the first start, and that each stream's memory tags follow its own issue order. Other behaviour is shown only by the bench's scenarios. These scenarios cover the exact run-ahead limit of seven instructions past a memory operation and the different effect of completing a younger operation versus the oldest one. They also cover a completion of a free tag, a restart of a running stream, the exact re-issue spacing, and the round-robin order. In each of these the bench's behavioural model predicts the issue outcome every cycle.

// File: rtl/sched_pkg.sv
// Package: shared helpers for the stream issue scheduler.
// Assumes callers pass a modulus of at least one.
package sched_pkg;

    // Default number of instructions a stream may issue past its oldest memory operation.
    parameter int unsigned DEF_LOOKAHEAD = 7;

    // Increment an index and wrap it back to zero at the modulus.
    function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned modulus);
        return (cur + 1 >= modulus) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/mem_window.sv
// Module: per-stream in-order window of outstanding memory operations.
// Each memory operation that issues takes the entry at the tail, and its issue
// sequence number is recorded there. The stream is held back once the oldest
// valid entry has LOOKAHEAD instructions issued after it. Assumes LOOKAHEAD+1
// is a power of two, so that the tail entry is always free when it is needed.
module mem_window #(
    parameter int unsigned LOOKAHEAD = sched_pkg::DEF_LOOKAHEAD,
    parameter int unsigned TAG_W     = $clog2(LOOKAHEAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             issue_mem,
    input  logic             cmp,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             ok,
    output logic [TAG_W-1:0] tail
);
    localparam int unsigned SLOTS = LOOKAHEAD + 1;
    localparam int unsigned SEQ_W = TAG_W + 1;

    logic [SLOTS-1:0] vld_q;
    logic [SEQ_W-1:0] pos_q [SLOTS];
    logic [SEQ_W-1:0] seq_q;
    logic [TAG_W-1:0] tail_q;

    assign tail = tail_q;

    // Block issue when any outstanding entry is SLOTS or more instructions old.
    always_comb begin
        ok = 1'b1;
        for (int e = 0; e < int'(SLOTS); e++) begin
            if (vld_q[e] && ((seq_q - pos_q[e]) >= SEQ_W'(SLOTS))) ok = 1'b0;
        end
    end

    // Retire completed entries, then record a new memory operation at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            seq_q  <= '0;
            tail_q <= '0;
            for (int e = 0; e < int'(SLOTS); e++) pos_q[e] <= '0;
        end else begin
            if (cmp) vld_q[cmp_tag] <= 1'b0;
            if (issue) begin
                seq_q <= seq_q + 1'b1;
                if (issue_mem) begin
                    vld_q[tail_q] <= 1'b1;
                    pos_q[tail_q] <= seq_q;
                    tail_q        <= tail_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/inflight_tracker.sv
// Module: marks a stream busy from its issue until its instruction leaves a
// fixed-latency pipeline. Assumes PIPE_LAT >= 1. The release happens on the
// edge where the issue reaches the last stage.
module inflight_tracker #(
    parameter int unsigned N_STREAMS = 128,
    parameter int unsigned SID_W     = $clog2(N_STREAMS),
    parameter int unsigned PIPE_LAT  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [SID_W-1:0]     issue_sid,
    output logic [N_STREAMS-1:0] busy
);
    logic [PIPE_LAT-1:0] stg_v;
    logic [SID_W-1:0]    stg_id [PIPE_LAT];

    // Shift each issue down the pipeline shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int k = 0; k < int'(PIPE_LAT); k++) stg_id[k] <= '0;
        end else begin
            stg_v[0]  <= issue_valid;
            stg_id[0] <= issue_sid;
            for (int k = 1; k < int'(PIPE_LAT); k++) begin
                stg_v[k]  <= stg_v[k-1];
                stg_id[k] <= stg_id[k-1];
            end
        end
    end

    // Set busy on issue and clear it when the last stage releases the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            for (int i = 0; i < int'(N_STREAMS); i++) begin
                if (stg_v[PIPE_LAT-1] && (stg_id[PIPE_LAT-1] == SID_W'(i))) busy[i] <= 1'b0;
                if (issue_valid && (issue_sid == SID_W'(i)))               busy[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_arbiter.sv
// Module: round-robin picker. It grants the first requester found by searching
// upward from a rotating pointer, with wrap-around. The pointer then moves to
// one past the granted index.
module rr_arbiter #(
    parameter int unsigned N_STREAMS = 128,
    parameter int unsigned SID_W     = $clog2(N_STREAMS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STREAMS-1:0] req,
    output logic                 gnt_valid,
    output logic [SID_W-1:0]     gnt_sid
);
    logic [SID_W-1:0] ptr_q;

    // Search from the pointer for the first request.
    always_comb begin
        int unsigned idx;
        gnt_valid = 1'b0;
        gnt_sid   = '0;
        for (int unsigned i = 0; i < N_STREAMS; i++) begin
            idx = int'(ptr_q) + i;
            if (idx >= N_STREAMS) idx = idx - N_STREAMS;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_sid   = SID_W'(idx);
            end
        end
    end

    // Move the pointer past the stream just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_q <= '0;
        else if (gnt_valid) ptr_q <= SID_W'(sched_pkg::wrap_inc(int'(gnt_sid), N_STREAMS));
    end
endmodule

// File: rtl/stream_issue_sched.sv
// Module: top of the stream issue scheduler. It keeps the active flag and PC
// for each stream, works out eligibility from the pipeline shadow, the memory
// window and the fetch-ready bits, and issues one stream per cycle through the
// round-robin picker. Assumes starts are sent only to streams that are meant
// to run. A branch redirect is not modelled: the PC steps by one per issue.
module stream_issue_sched #(
    parameter int unsigned N_STREAMS = 128,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned PIPE_LAT  = 4,
    parameter int unsigned LOOKAHEAD = sched_pkg::DEF_LOOKAHEAD,
    localparam int unsigned SID_W    = $clog2(N_STREAMS),
    localparam int unsigned TAG_W    = $clog2(LOOKAHEAD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_valid,
    input  logic [SID_W-1:0]     start_sid,
    input  logic [PC_W-1:0]      start_pc,
    input  logic [N_STREAMS-1:0] inst_rdy,
    input  logic [N_STREAMS-1:0] mem_slot,
    input  logic                 cmp_valid,
    input  logic [SID_W-1:0]     cmp_sid,
    input  logic [TAG_W-1:0]     cmp_tag,
    output logic                 issue_valid,
    output logic [SID_W-1:0]     issue_sid,
    output logic [PC_W-1:0]      issue_pc,
    output logic                 issue_mem,
    output logic [TAG_W-1:0]     issue_tag
);
    logic [N_STREAMS-1:0] active_q;
    logic [PC_W-1:0]      pc_q [N_STREAMS];
    logic [N_STREAMS-1:0] busy;
    logic [N_STREAMS-1:0] win_ok;
    logic [N_STREAMS-1:0] elig;
    logic [TAG_W-1:0]     tail_tag [N_STREAMS];

    // A stream may issue only when it is running, idle in the pipe, inside its window and fetched.
    assign elig = active_q & ~busy & win_ok & inst_rdy;

    // One memory window per stream.
    for (genvar g = 0; g < int'(N_STREAMS); g++) begin : g_win
        mem_window #(.LOOKAHEAD(LOOKAHEAD), .TAG_W(TAG_W)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue     (issue_valid && (issue_sid == SID_W'(g))),
            .issue_mem (mem_slot[g]),
            .cmp       (cmp_valid && (cmp_sid == SID_W'(g))),
            .cmp_tag   (cmp_tag),
            .ok        (win_ok[g]),
            .tail      (tail_tag[g])
        );
    end

    inflight_tracker #(.N_STREAMS(N_STREAMS), .SID_W(SID_W), .PIPE_LAT(PIPE_LAT)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_sid   (issue_sid),
        .busy        (busy)
    );

    rr_arbiter #(.N_STREAMS(N_STREAMS), .SID_W(SID_W)) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (elig),
        .gnt_valid (issue_valid),
        .gnt_sid   (issue_sid)
    );

    // Drive the issue fields of the chosen stream.
    assign issue_pc  = pc_q[issue_sid];
    assign issue_mem = issue_valid & mem_slot[issue_sid];
    assign issue_tag = issue_mem ? tail_tag[issue_sid] : '0;

    // Keep each stream's active flag and PC: load on start, step on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            for (int i = 0; i < int'(N_STREAMS); i++) pc_q[i] <= '0;
        end else begin
            for (int i = 0; i < int'(N_STREAMS); i++) begin
                if (issue_valid && (issue_sid == SID_W'(i))) pc_q[i] <= pc_q[i] + 1'b1;
                if (start_valid && (start_sid == SID_W'(i)) && !active_q[i]) begin
                    active_q[i] <= 1'b1;
                    pc_q[i]     <= start_pc;
                end
            end
        end
    end
endmodule

// File: rtl/stream_issue_sched_chk.sv
// Module: property checker for the stream issue scheduler, bound to the top.
// It sees only the top's ports and keeps a small per-stream tag counter of its own.
module stream_issue_sched_chk #(
    parameter int unsigned N_STREAMS = 128,
    parameter int unsigned SID_W     = 7,
    parameter int unsigned TAG_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_valid,
    input logic [N_STREAMS-1:0] inst_rdy,
    input logic                 issue_valid,
    input logic [SID_W-1:0]     issue_sid,
    input logic                 issue_mem,
    input logic [TAG_W-1:0]     issue_tag
);
    logic             any_start_q;
    logic [TAG_W-1:0] tag_cnt [N_STREAMS];

    // Note whether any start has been seen, and count memory issues per stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_start_q <= 1'b0;
            for (int i = 0; i < int'(N_STREAMS); i++) tag_cnt[i] <= '0;
        end else begin
            if (start_valid) any_start_q <= 1'b1;
            if (issue_valid && issue_mem) tag_cnt[issue_sid] <= tag_cnt[issue_sid] + 1'b1;
        end
    end

    AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !any_start_q |-> !issue_valid); // R1
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && (issue_sid == $past(issue_sid)))); // R4
    AST_TAG_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_mem) |-> (issue_tag == tag_cnt[issue_sid])); // R6
    AST_TAG_ZERO_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_mem |-> (issue_tag == '0)); // R6
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !issue_mem); // R9
    AST_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> inst_rdy[issue_sid]); // R10
endmodule

bind stream_issue_sched stream_issue_sched_chk #(
    .N_STREAMS (N_STREAMS),
    .SID_W     (SID_W),
    .TAG_W     (TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .inst_rdy    (inst_rdy),
    .issue_valid (issue_valid),
    .issue_sid   (issue_sid),
    .issue_mem   (issue_mem),
    .issue_tag   (issue_tag)
);

// File: tb/stream_issue_sched_tb.sv
// Bench: a behavioural reference model (queues and integers) predicts each
// cycle's issue. The model's prediction is compared with the outputs every
// clock, and directed phases test the window, restart and spacing rules.
module stream_issue_sched_tb;
    localparam int NS = 8;
    localparam int SW = 3;
    localparam int PL = 3;
    localparam int LOOK = 7;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic [SW-1:0] start_sid = '0;
    logic [31:0]   start_pc = '0;
    logic [NS-1:0] inst_rdy = '0;
    logic [NS-1:0] mem_slot = '0;
    logic          cmp_valid = 1'b0;
    logic [SW-1:0] cmp_sid = '0;
    logic [TW-1:0] cmp_tag = '0;
    logic          issue_valid;
    logic [SW-1:0] issue_sid;
    logic [31:0]   issue_pc;
    logic          issue_mem;
    logic [TW-1:0] issue_tag;

    always #4 clk = ~clk;

    stream_issue_sched #(.N_STREAMS(NS), .PC_W(32), .PIPE_LAT(PL), .LOOKAHEAD(LOOK)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_sid(start_sid),
        .start_pc(start_pc), .inst_rdy(inst_rdy), .mem_slot(mem_slot), .cmp_valid(cmp_valid),
        .cmp_sid(cmp_sid), .cmp_tag(cmp_tag), .issue_valid(issue_valid), .issue_sid(issue_sid),
        .issue_pc(issue_pc), .issue_mem(issue_mem), .issue_tag(issue_tag)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int act_m [NS];
    longint pc_m [NS];
    int ok_at [NS];
    int iss_n [NS];
    int tail_m [NS];
    int rr_m = 0;
    int q_t [NS][$];
    int q_i [NS][$];
    int obs0 = 0;
    int last0 = -1;
    int gap_chk = 0;
    longint obs_pc = 0;
    int obs_tag = 0;

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit elig(input int s);
        if (act_m[s] == 0) return 1'b0;
        if (cyc < ok_at[s]) return 1'b0;
        if (!inst_rdy[s]) return 1'b0;
        if (q_i[s].size() > 0 && (iss_n[s] - q_i[s][0]) > LOOK) return 1'b0;
        return 1'b1;
    endfunction

    // Predict, compare, advance the model by one edge, then clear the pulses.
    task automatic tick();
        bit ev;
        int es;
        #1;
        ev = 1'b0;
        es = 0;
        for (int i = 0; i < NS; i++) begin
            int x;
            x = (rr_m + i) % NS;
            if (!ev && elig(x)) begin ev = 1'b1; es = x; end
        end
        chk(issue_valid === ev, "R9 issue_valid", longint'(issue_valid), longint'(ev));
        if (ev && issue_valid) begin
            chk(int'(issue_sid) == es, "R8 issue_sid", longint'(issue_sid), es);
            chk(longint'(issue_pc) == pc_m[es], "R3 issue_pc", longint'(issue_pc), pc_m[es]);
            chk(issue_mem == mem_slot[es], "R10 issue_mem", longint'(issue_mem), longint'(mem_slot[es]));
            chk(int'(issue_tag) == (mem_slot[es] ? tail_m[es] : 0), "R6 issue_tag",
                longint'(issue_tag), mem_slot[es] ? tail_m[es] : 0);
        end else if (!ev) begin
            chk(issue_mem == 1'b0, "R9 issue_mem on stall", longint'(issue_mem), 0);
        end
        if (issue_valid && issue_sid == 0) begin
            obs0++;
            obs_pc = longint'(issue_pc);
            obs_tag = int'(issue_tag);
            if (gap_chk != 0 && last0 >= 0)
                chk(cyc - last0 == PL + 1, "R4 reissue spacing", cyc - last0, PL + 1);
            last0 = cyc;
        end
        if (cmp_valid) begin
            for (int k = 0; k < q_t[cmp_sid].size(); k++) begin
                if (q_t[cmp_sid][k] == int'(cmp_tag)) begin
                    q_t[cmp_sid].delete(k);
                    q_i[cmp_sid].delete(k);
                    break;
                end
            end
        end
        if (ev) begin
            if (mem_slot[es]) begin
                q_t[es].push_back(tail_m[es]);
                q_i[es].push_back(iss_n[es]);
                tail_m[es] = (tail_m[es] + 1) % (LOOK + 1);
            end
            iss_n[es]++;
            pc_m[es] = (pc_m[es] + 1) & 64'hFFFF_FFFF;
            ok_at[es] = cyc + PL + 1;
            rr_m = (es + 1) % NS;
        end
        if (start_valid && act_m[start_sid] == 0) begin
            act_m[start_sid] = 1;
            pc_m[start_sid] = longint'(start_pc);
        end
        cyc++;
        @(negedge clk);
        start_valid = 1'b0;
        cmp_valid = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_start(input int s, input int pc);
        start_valid = 1'b1;
        start_sid = SW'(s);
        start_pc = 32'(pc);
        tick();
    endtask

    task automatic do_cmp(input int s, input int t);
        cmp_valid = 1'b1;
        cmp_sid = SW'(s);
        cmp_tag = TW'(t);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            act_m[s] = 0; pc_m[s] = 0; ok_at[s] = 0; iss_n[s] = 0; tail_m[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        inst_rdy = '1;
        mem_slot = '1;
        // R1: no stream started, so nothing issues.
        for (int i = 0; i < 5; i++) begin
            #1;
            chk(issue_valid == 1'b0, "R1 idle after reset", longint'(issue_valid), 0);
            tick();
        end
        // R5 and R4: a single stream issuing memory words stops after 8 issues.
        do_start(0, 100);
        obs0 = 0;
        gap_chk = 1;
        run(40);
        gap_chk = 0;
        chk(obs0 == 8, "R5 issues before oldest completes", obs0, 8);
        // R11: completing a younger operation does not release the stream.
        obs0 = 0;
        do_cmp(0, 3);
        run(12);
        chk(obs0 == 0, "R11 younger completion keeps block", obs0, 0);
        // R11: completing the oldest releases exactly one more issue.
        obs0 = 0;
        do_cmp(0, 0);
        run(12);
        chk(obs0 == 1, "R11 oldest completion releases", obs0, 1);
        chk(obs_pc == 108, "R3 pc after eight issues", obs_pc, 108);
        chk(obs_tag == 0, "R6 tag wraps to 0", obs_tag, 0);
        // R2: restarting a running stream leaves its PC alone.
        do_start(0, 500);
        obs0 = 0;
        do_cmp(0, 1);
        run(12);
        chk(obs0 == 1, "R2 issue after restart attempt", obs0, 1);
        chk(obs_pc == 109, "R2 pc unchanged by restart", obs_pc, 109);
        // R7: a completion for a tag that is not outstanding is ignored.
        obs0 = 0;
        do_cmp(0, 3);
        run(12);
        chk(obs0 == 0, "R7 stale completion ignored", obs0, 0);
        // Mixed traffic for R8, R10 and the rest, checked by the model each cycle.
        for (int i = 0; i < 4000; i++) begin
            inst_rdy = NS'($urandom);
            inst_rdy = inst_rdy | NS'($urandom);
            mem_slot = NS'($urandom);
            if ($urandom_range(0, 19) == 0) begin
                start_valid = 1'b1;
                start_sid = SW'($urandom_range(0, NS - 1));
                start_pc = $urandom;
            end
            begin
                int s;
                s = $urandom_range(0, NS - 1);
                if (q_t[s].size() > 0 && $urandom_range(0, 9) < 7) begin
                    cmp_valid = 1'b1;
                    cmp_sid = SW'(s);
                    cmp_tag = TW'(q_t[s][$urandom_range(0, q_t[s].size() - 1)]);
                end else if ($urandom_range(0, 9) == 0) begin
                    cmp_valid = 1'b1;
                    cmp_sid = SW'(s);
                    cmp_tag = TW'($urandom_range(0, LOOK));
                end
            end
            tick();
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule